// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block carries out the one-bit logic and move operations of a small controller core. Each request names an operation, an 8-bit bit address, the current carry flag, the byte stored at the addressed location and, for port locations, the byte seen on the pins. The block turns the bit address into a byte address and a bit position. It then works out the new carry, the new bit value and the merged byte to write back, together with one write strobe for the carry and one for the byte.

The byte address and bit position appear combinationally on the read side, so the enclosing datapath can fetch the byte in the same cycle. The results are registered and show up one clock after the request. The storage array, the special-register file and the port pins themselves live outside this block.

Bit positions 0 to 7 of the status byte at 0xD0 are reached through bit addresses 0xD0 to 0xD7, and 0xD7 is the carry flag. The block treats that address as the carry itself, so a bit operation there updates the flag directly.

Top module: `bitproc_unit`

## Requirements
- R1: Bit addresses 0x00 to 0x7F map to byte address 0x20 plus bit_addr[6:3], with bit position bit_addr[2:0]. The mapping appears combinationally on rd_byte_addr and rd_bit_pos, and on wr_byte_addr and wr_bit_pos one cycle after the request.
- R2: Bit addresses 0x80 to 0xFF map to byte address {bit_addr[7:3],3'b000}, with bit position bit_addr[2:0].
- R3: Op code 1 (AND into carry) gives carry AND source bit. Op code 2 (AND inverted into carry) gives carry AND NOT source bit. Both raise only carry_we, never bit_we, so the source byte is never written.
- R4: Op code 3 (OR into carry) gives carry OR source bit. Op code 4 (OR inverted into carry) gives carry OR NOT source bit. Both raise only carry_we.
- R5: Op code 5 (copy bit to carry) loads the source bit into the carry and raises only carry_we.
- R6: Op code 6 (copy carry to bit) raises bit_we. The written byte equals mem_byte with the addressed position replaced by carry_in and the other seven bits unchanged.
- R7: Op codes 7, 8 and 9 clear, set and invert the carry. They raise carry_we and never bit_we.
- R8: Op codes 10, 11 and 12 clear, set and invert the addressed bit. They raise bit_we, take the old value from mem_byte and leave the other seven bits of the byte unchanged. They raise carry_we only for the carry address of R10.
- R9: Port locations are bytes 0x80, 0x90, 0xA0 and 0xB0. The carry-logic and copy-to-carry ops (codes 1 to 5) read a port bit from pin_byte. The bit-modify ops (codes 6, 10, 11, 12) take the byte from mem_byte, which is the output latch.
- R10: At bit address 0xD7, the source and old bit value is carry_in. A bit write there also raises carry_we, with carry_out equal to bit_out.
- R11: The strobes rise exactly one cycle after a request with op_valid high. An idle cycle, op code 0 or op codes 13 to 15 leave both strobes low.
- R12: While rst_n is low, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request qualifier |
| op_code | input | 4 | Operation select |
| bit_addr | input | 8 | Bit address |
| carry_in | input | 1 | Current carry flag |
| mem_byte | input | 8 | Stored byte (RAM, register or port latch) at rd_byte_addr |
| pin_byte | input | 8 | Pin value for port locations |
| rd_byte_addr | output | 8 | Byte address decoded from bit_addr |
| rd_bit_pos | output | 3 | Bit position decoded from bit_addr |
| carry_we | output | 1 | Carry write strobe |
| carry_out | output | 1 | New carry value |
| bit_we | output | 1 | Byte write strobe |
| bit_out | output | 1 | New value of the addressed bit |
| wr_byte | output | 8 | Merged byte to write back |
| wr_byte_addr | output | 8 | Write byte address |
| wr_bit_pos | output | 3 | Write bit position |

## Verification
The bench drives port locations with pin and latch values that differ. A unit that read the pins for a set, clear or invert op would write a corrupted byte, and one that read the latch for a carry op would return the wrong carry. It hits address 0xD7, where a unit without the carry alias would drop the flag update or use a stale stored bit. It checks that the inverted-source ops raise no byte strobe, and it compares the merged byte at every position to catch neighbouring bits being overwritten. It also checks the region boundaries 0x7F/0x80 and idle or unused codes, where a wrong decode gives a wrong byte address or spurious strobes.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

    typedef enum logic [3:0] {
        BOP_NOP    = 4'd0,
        BOP_AND_C  = 4'd1,
        BOP_ANDN_C = 4'd2,
        BOP_OR_C   = 4'd3,
        BOP_ORN_C  = 4'd4,
        BOP_LD_C   = 4'd5,
        BOP_ST_C   = 4'd6,
        BOP_CLR_C  = 4'd7,
        BOP_SET_C  = 4'd8,
        BOP_INV_C  = 4'd9,
        BOP_CLR_B  = 4'd10,
        BOP_SET_B  = 4'd11,
        BOP_INV_B  = 4'd12
    } bop_e;

    typedef struct packed {
        logic       carry_we;
        logic       carry_val;
        logic       bit_we;
        logic       bit_val;
        logic [7:0] wr_byte;
        logic [7:0] wr_addr;
        logic [2:0] wr_pos;
    } bres_t;

endpackage

// File: rtl/bitproc_addr_map.sv
module bitproc_addr_map #(
    parameter int               ADDR_W      = 8,
    parameter int               POS_W       = 3,
    parameter logic [ADDR_W-1:0] RAM_BASE    = 8'h20,
    parameter int               PORT_COUNT  = 4,
    parameter logic [ADDR_W-1:0] STATUS_BYTE = 8'hD0,
    parameter int               CARRY_POS   = 7
) (
    input  logic [ADDR_W-1:0] bit_addr,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [POS_W-1:0]  bit_pos,
    output logic              is_port,
    output logic              is_carry
);
    localparam int OFF_W = ADDR_W - 1 - POS_W;
    localparam int ROW_W = OFF_W - 1;

    logic [OFF_W-1:0] ram_off;
    logic [ROW_W-1:0] sfr_row;
    logic             hi_region;

    assign ram_off   = bit_addr[ADDR_W-2:POS_W];
    assign sfr_row   = bit_addr[ADDR_W-2:POS_W+1];
    assign hi_region = bit_addr[ADDR_W-1];

    always_comb begin
        bit_pos = bit_addr[POS_W-1:0];
        if (hi_region) begin
            byte_addr = {bit_addr[ADDR_W-1:POS_W], {POS_W{1'b0}}};
        end else begin
            byte_addr = RAM_BASE + ADDR_W'(ram_off);
        end
        is_port  = hi_region && !bit_addr[POS_W]
                   && ({1'b0, sfr_row} < (ROW_W+1)'(PORT_COUNT));
        is_carry = (byte_addr == STATUS_BYTE) && (bit_pos == POS_W'(CARRY_POS));
    end

endmodule

// File: rtl/bitproc_bit_alu.sv
module bitproc_bit_alu
    import bitproc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int POS_W  = 3
) (
    input  bop_e              op,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] mem_byte,
    input  logic [DATA_W-1:0] pin_byte,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              is_port,
    input  logic              is_carry,
    output logic              carry_we,
    output logic              carry_val,
    output logic              bit_we,
    output logic              bit_val,
    output logic [DATA_W-1:0] wr_byte
);
    logic src_bit;   // operand for carry logic (pins for ports)
    logic old_bit;   // base value for read-modify-write (latch)
    logic new_bit;

    always_comb begin
        if (is_carry) begin
            src_bit = carry_in;
            old_bit = carry_in;
        end else begin
            src_bit = is_port ? pin_byte[bit_pos] : mem_byte[bit_pos];
            old_bit = mem_byte[bit_pos];
        end
    end

    always_comb begin
        carry_we  = 1'b0;
        carry_val = carry_in;
        bit_we    = 1'b0;
        new_bit   = old_bit;
        unique case (op)
            BOP_AND_C:  begin carry_we = 1'b1; carry_val = carry_in &  src_bit; end
            BOP_ANDN_C: begin carry_we = 1'b1; carry_val = carry_in & ~src_bit; end
            BOP_OR_C:   begin carry_we = 1'b1; carry_val = carry_in |  src_bit; end
            BOP_ORN_C:  begin carry_we = 1'b1; carry_val = carry_in | ~src_bit; end
            BOP_LD_C:   begin carry_we = 1'b1; carry_val = src_bit;             end
            BOP_CLR_C:  begin carry_we = 1'b1; carry_val = 1'b0;                end
            BOP_SET_C:  begin carry_we = 1'b1; carry_val = 1'b1;                end
            BOP_INV_C:  begin carry_we = 1'b1; carry_val = ~carry_in;           end
            BOP_ST_C:   begin bit_we = 1'b1; new_bit = carry_in;  end
            BOP_CLR_B:  begin bit_we = 1'b1; new_bit = 1'b0;      end
            BOP_SET_B:  begin bit_we = 1'b1; new_bit = 1'b1;      end
            BOP_INV_B:  begin bit_we = 1'b1; new_bit = ~old_bit;  end
            default:    begin end
        endcase
        // A bit write on the carry alias is a carry write as well
        if (bit_we && is_carry) begin
            carry_we  = 1'b1;
            carry_val = new_bit;
        end
        bit_val = new_bit;
    end

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_merge
            assign wr_byte[g] = (bit_pos == POS_W'(g)) ? new_bit : mem_byte[g];
        end
    endgenerate

endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
    import bitproc_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 8,
    parameter logic [7:0] RAM_BASE    = 8'h20,
    parameter int         PORT_COUNT  = 4,
    parameter logic [7:0] STATUS_BYTE = 8'hD0,
    parameter int         CARRY_POS   = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [3:0]  op_code,
    input  logic [7:0]  bit_addr,
    input  logic        carry_in,
    input  logic [7:0]  mem_byte,
    input  logic [7:0]  pin_byte,
    output logic [7:0]  rd_byte_addr,
    output logic [2:0]  rd_bit_pos,
    output logic        carry_we,
    output logic        carry_out,
    output logic        bit_we,
    output logic        bit_out,
    output logic [7:0]  wr_byte,
    output logic [7:0]  wr_byte_addr,
    output logic [2:0]  wr_bit_pos
);
    localparam int POS_W = $clog2(DATA_W);

    logic       m_port, m_carry;
    logic       a_cwe, a_cval, a_bwe, a_bval;
    logic [7:0] a_byte;
    bop_e       op;
    bres_t      res_d, res_q;

    assign op = bop_e'(op_code);

    bitproc_addr_map #(
        .ADDR_W(ADDR_W), .POS_W(POS_W), .RAM_BASE(RAM_BASE),
        .PORT_COUNT(PORT_COUNT), .STATUS_BYTE(STATUS_BYTE), .CARRY_POS(CARRY_POS)
    ) u_map (
        .bit_addr (bit_addr),
        .byte_addr(rd_byte_addr),
        .bit_pos  (rd_bit_pos),
        .is_port  (m_port),
        .is_carry (m_carry)
    );

    bitproc_bit_alu #(.DATA_W(DATA_W), .POS_W(POS_W)) u_alu (
        .op       (op),
        .carry_in (carry_in),
        .mem_byte (mem_byte),
        .pin_byte (pin_byte),
        .bit_pos  (rd_bit_pos),
        .is_port  (m_port),
        .is_carry (m_carry),
        .carry_we (a_cwe),
        .carry_val(a_cval),
        .bit_we   (a_bwe),
        .bit_val  (a_bval),
        .wr_byte  (a_byte)
    );

    always_comb begin
        res_d          = res_q;
        res_d.carry_we = 1'b0;
        res_d.bit_we   = 1'b0;
        if (op_valid) begin
            res_d.carry_we  = a_cwe;
            res_d.carry_val = a_cval;
            res_d.bit_we    = a_bwe;
            res_d.bit_val   = a_bval;
            res_d.wr_byte   = a_byte;
            res_d.wr_addr   = rd_byte_addr;
            res_d.wr_pos    = rd_bit_pos;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign carry_we     = res_q.carry_we;
    assign carry_out    = res_q.carry_val;
    assign bit_we       = res_q.bit_we;
    assign bit_out      = res_q.bit_val;
    assign wr_byte      = res_q.wr_byte;
    assign wr_byte_addr = res_q.wr_addr;
    assign wr_bit_pos   = res_q.wr_pos;

    // Strobes only follow a qualified request
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_valid) |-> (!carry_we && !bit_we));

    // Inverted-source carry ops never write the source byte
    p_inv_src_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && (op_code == 4'd2 || op_code == 4'd4)) |-> !bit_we);

    // Carry-only ops leave the byte alone
    p_carry_ops_no_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_code >= 4'd7 && op_code <= 4'd9) |-> (carry_we && !bit_we));

    // Written byte differs from the read byte at most at the addressed position
    p_merge_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_we |-> (((wr_byte ^ $past(mem_byte)) & ~(8'h01 << wr_bit_pos)) == 8'h00));

    // Bit write on the status carry position also updates the carry
    p_status_alias_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && wr_byte_addr == STATUS_BYTE && wr_bit_pos == 3'(CARRY_POS))
        |-> (carry_we && carry_out == bit_out));

    // Lower half of the bit space lands in the 16-byte window
    p_ram_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_addr[7] |-> (rd_byte_addr >= RAM_BASE && rd_byte_addr < RAM_BASE + 8'd16));

    // Upper half maps to an 8-aligned register byte
    p_sfr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_addr[7] |-> (rd_byte_addr[2:0] == 3'b000 && rd_byte_addr[7]));

endmodule

// File: tb/bitproc_unit_bench.sv
module bitproc_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [3:0] op_code;
    logic [7:0] bit_addr;
    logic       carry_in;
    logic [7:0] mem_byte, pin_byte;
    logic [7:0] rd_byte_addr, wr_byte, wr_byte_addr;
    logic [2:0] rd_bit_pos, wr_bit_pos;
    logic       carry_we, carry_out, bit_we, bit_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bitproc_unit u_bitproc_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .bit_addr(bit_addr), .carry_in(carry_in), .mem_byte(mem_byte),
        .pin_byte(pin_byte), .rd_byte_addr(rd_byte_addr), .rd_bit_pos(rd_bit_pos),
        .carry_we(carry_we), .carry_out(carry_out), .bit_we(bit_we),
        .bit_out(bit_out), .wr_byte(wr_byte), .wr_byte_addr(wr_byte_addr),
        .wr_bit_pos(wr_bit_pos)
    );

    function automatic logic [7:0] exp_addr(input logic [7:0] a);
        if (a < 8'h80) return 8'h20 + {4'h0, a[6:3]};
        return a & 8'hF8;
    endfunction

    function automatic bit exp_port(input logic [7:0] a);
        logic [7:0] b = exp_addr(a);
        return (b == 8'h80) || (b == 8'h90) || (b == 8'hA0) || (b == 8'hB0);
    endfunction

    // {cwe, cval, bwe, bval, byte}
    function automatic logic [11:0] model(input logic v, input logic [3:0] op,
            input logic [7:0] a, input logic c, input logic [7:0] m, input logic [7:0] p);
        logic alias_c = (a == 8'hD7);
        logic sb, ob, nb, cwe, cv, bwe;
        logic [7:0] by;
        sb = alias_c ? c : (exp_port(a) ? p[a[2:0]] : m[a[2:0]]);
        ob = alias_c ? c : m[a[2:0]];
        cwe = 0; cv = c; bwe = 0; nb = ob;
        case (op)
            4'd1: begin cwe = 1; cv = c & sb;  end
            4'd2: begin cwe = 1; cv = c & !sb; end
            4'd3: begin cwe = 1; cv = c | sb;  end
            4'd4: begin cwe = 1; cv = c | !sb; end
            4'd5: begin cwe = 1; cv = sb;      end
            4'd6: begin bwe = 1; nb = c;       end
            4'd7: begin cwe = 1; cv = 0;       end
            4'd8: begin cwe = 1; cv = 1;       end
            4'd9: begin cwe = 1; cv = !c;      end
            4'd10: begin bwe = 1; nb = 0;      end
            4'd11: begin bwe = 1; nb = 1;      end
            4'd12: begin bwe = 1; nb = !ob;    end
            default: ;
        endcase
        if (bwe && alias_c) begin cwe = 1; cv = nb; end
        by = m;
        by[a[2:0]] = nb;
        if (!v) begin cwe = 0; bwe = 0; end
        return {cwe, cv, bwe, nb, by};
    endfunction

    function automatic string tag_of(input logic v, input logic [3:0] op, input logic [7:0] a);
        if (!v || op == 4'd0 || op > 4'd12) return "R11";
        if (a == 8'hD7) return "R10";
        if (exp_port(a)) return "R9";
        case (op)
            4'd1, 4'd2: return "R3";
            4'd3, 4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7, 4'd8, 4'd9: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic do_op(input logic v, input logic [3:0] op, input logic [7:0] a,
            input logic c, input logic [7:0] m, input logic [7:0] p);
        logic [11:0] e, g;
        string t;
        op_valid = v; op_code = op; bit_addr = a; carry_in = c; mem_byte = m; pin_byte = p;
        #1;
        checks++;
        if (rd_byte_addr !== exp_addr(a) || rd_bit_pos !== a[2:0]) begin
            errors++;
            $display("FAIL %s addr %h: got %h/%0d exp %h/%0d", a[7] ? "R2" : "R1",
                     a, rd_byte_addr, rd_bit_pos, exp_addr(a), a[2:0]);
        end
        e = model(v, op, a, c, m, p);
        t = tag_of(v, op, a);
        @(negedge clk);
        g = {carry_we, carry_out, bit_we, bit_out, wr_byte};
        checks++;
        if (g[11] !== e[11] || (e[11] && g[10] !== e[10]) || g[9] !== e[9]
            || (e[9] && (g[8:0] !== e[8:0] || wr_byte_addr !== exp_addr(a)
                         || wr_bit_pos !== a[2:0]))) begin
            errors++;
            $display("FAIL %s op %0d addr %h: got %b exp %b", t, op, a, g, e);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0B17));
        rst_n = 0; op_valid = 0; op_code = 0; bit_addr = 0;
        carry_in = 0; mem_byte = 0; pin_byte = 0;
        repeat (3) @(negedge clk);
        checks++;
        if ({carry_we, carry_out, bit_we, bit_out, wr_byte, wr_byte_addr, wr_bit_pos} !== '0) begin
            errors++;
            $display("FAIL R12 reset outputs: got %b exp 0",
                     {carry_we, carry_out, bit_we, bit_out, wr_byte, wr_byte_addr, wr_bit_pos});
        end
        rst_n = 1;
        // R1/R2 region edges
        do_op(1, 4'd11, 8'h00, 0, 8'h00, 8'h00);
        do_op(1, 4'd11, 8'h7F, 0, 8'h00, 8'h00);
        do_op(1, 4'd10, 8'h80, 0, 8'hFF, 8'h00);
        do_op(1, 4'd6,  8'hE5, 1, 8'h00, 8'h00);   // R6 single bit merge
        // R9 latch 0x5D, clear position 2 -> 0x59; pins disagree
        do_op(1, 4'd10, 8'h92, 0, 8'h5D, 8'hA2);
        do_op(1, 4'd5,  8'h91, 0, 8'h00, 8'h02);   // R9 carry reads pins
        do_op(1, 4'd12, 8'hA3, 0, 8'h08, 8'h00);   // R9 invert uses latch
        // R3/R4 inverted forms, no byte write
        do_op(1, 4'd2, 8'h2C, 1, 8'h10, 8'h00);
        do_op(1, 4'd4, 8'h2C, 0, 8'h00, 8'h00);
        do_op(1, 4'd1, 8'h05, 1, 8'h00, 8'h00);
        // R10 carry alias
        do_op(1, 4'd12, 8'hD7, 1, 8'h80, 8'h00);
        do_op(1, 4'd11, 8'hD7, 0, 8'h00, 8'h00);
        // R7, R11 idle and unused code
        do_op(1, 4'd9, 8'h33, 1, 8'h00, 8'h00);
        do_op(0, 4'd8, 8'h33, 0, 8'h00, 8'h00);
        do_op(1, 4'd15, 8'h40, 1, 8'hFF, 8'h00);
        do_op(1, 4'd0, 8'h40, 1, 8'hFF, 8'h00);
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            int sel = $urandom_range(0, 3);
            a = 8'($urandom);
            if (sel == 0) a = 8'hD7;
            else if (sel == 1) a = {2'b10, 2'($urandom), 1'b0, 3'($urandom)};
            do_op(($urandom_range(0, 7) != 0), 4'($urandom_range(0, 15)), a,
                  1'($urandom), 8'($urandom), 8'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule